// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block sits at the command pins of a two-bank synchronous DRAM model. Each cycle it turns the chip-select, row-strobe, column-strobe and write-enable levels, the address bus and the clock-enable input into exactly one decoded command. It reports that command as a one-hot strobe, together with the bank index, the row and column fields, and the two address-bit-10 qualifiers. The decoder keeps a registered copy of clock enable, so the same pin pattern means different things depending on whether clock enable was high or low one cycle earlier.

Alongside the decoder the block keeps an open/closed flag for each bank, a burst-in-progress tracker driven by the captured burst length, a four-state power state (running, power-down, self-refresh, clock suspend), and the operating code captured by a mode register set. Any command that is not allowed in the present state raises a one-cycle error flag and leaves the bank flags untouched. A surrounding model uses the strobes and state to drive its array, refresh and data logic.

Top module: `sdcmd_tracker`

## Requirements
- R1: In a running cycle (power state running, clock enable high now and in the previous cycle) with chip select high, only the deselect strobe (bit 1) is raised, no error is flagged and no bank flag changes, whatever the other pins show.
- R2: In a running cycle with chip select low, the pins {row strobe, column strobe, write enable} decode as 011 open-row (bit 2), 010 precharge (bit 3), 101 read (bit 4), 100 write (bit 5), 000 mode set (bit 6), 111 no-op (bit 0), 110 burst stop (bit 7); at most one strobe bit is ever high.
- R3: Pattern 001 with chip select low is auto refresh (bit 8) when clock enable is high in both cycles, and self-refresh entry (bit 9, power state 2) when clock enable was high and is now low with both banks closed.
- R4: Address bit 11 is the bank index, bits 10..0 the row and bits 7..0 the column; bit 10 raises the auto-precharge flag on a read or write and the precharge-both flag on a precharge.
- R5: A legal open-row sets the addressed bank's flag in the next cycle; a precharge clears the addressed bank's flag, or both flags when bit 10 is high. Bank flags are bit 0 and bit 1 of the bank-open output.
- R6: Open-row to an open bank, read or write to a closed bank, mode set or auto refresh with any bank open, burst stop with no bank open, and the self-refresh pattern at a clock-enable fall with a bank open each raise the error flag for that cycle and change no bank flag.
- R7: A legal mode set captures address bits 2..0 as burst-length code, bit 3 as interleave select and bits 6..4 as read latency; after reset these read 0, 0 and 2.
- R8: A read or write starts a burst that is busy for the next N running cycles, N being 1, 2, 4 or 8 for length codes 0 to 3 (other codes except 7 give 1); code 7 stays busy until burst stop, a precharge of its bank, or another read or write.
- R9: A read or write with auto-precharge closes its bank at the end of the running cycle in which its burst ends.
- R10: A clock-enable fall in the running state enters clock suspend (power state 3, bit 13) when a burst is busy and power-down (state 1, bit 11) otherwise; the burst count does not advance outside running cycles.
- R11: A clock-enable rise leaves clock suspend (bit 14) whatever the pins; it leaves power-down (bit 12) or self-refresh (bit 10) only if the pins show deselect or no-op, otherwise the error flag rises and the state is kept.
- R12: After reset both banks are closed, the power state is running (0) and no burst is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable, sampled each edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 12 | Bank bit 11, row/op-code bits 10..0 |
| cmd_stb | output | 15 | One-hot decoded command |
| cmd_illegal | output | 1 | Command not allowed in present state |
| cmd_bank | output | 1 | Addressed bank |
| cmd_row | output | 11 | Row field |
| cmd_col | output | 8 | Column field |
| cmd_autopre | output | 1 | Read/write with auto-precharge |
| cmd_pre_all | output | 1 | Precharge of both banks |
| bank_open | output | 2 | Per-bank open flag |
| pwr_state | output | 2 | 0 run, 1 power-down, 2 self-refresh, 3 suspend |
| burst_busy | output | 1 | Burst in progress |
| mode_bl | output | 3 | Captured burst-length code |
| mode_ilv | output | 1 | Captured interleave select |
| mode_cl | output | 3 | Captured read latency |

## Verification
Directed sequences walk one bank through open, auto-precharged read of four beats and close, so the exact cycle of the close is separated from an off-by-one burst count. A write burst is frozen by a clock-enable fall and released with read pins present, which separates suspend exit from a real read and shows the count not moving. Self-refresh and power-down are entered and left with both a legal and an illegal pin pattern, telling the history-dependent decode apart from plain pin decoding. A long seeded random run with rare clock-enable drops and occasional deselects then compares every output each cycle with a bench model, reaching full-page bursts, illegal commands and collisions between auto-precharge and new commands.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [3:0] {
        CMD_NOP      = 4'd0,
        CMD_DESEL    = 4'd1,
        CMD_ACT      = 4'd2,
        CMD_PRE      = 4'd3,
        CMD_READ     = 4'd4,
        CMD_WRITE    = 4'd5,
        CMD_MRS      = 4'd6,
        CMD_BST      = 4'd7,
        CMD_AREF     = 4'd8,
        CMD_SREF_IN  = 4'd9,
        CMD_SREF_OUT = 4'd10,
        CMD_PD_IN    = 4'd11,
        CMD_PD_OUT   = 4'd12,
        CMD_SUSP_IN  = 4'd13,
        CMD_SUSP_OUT = 4'd14,
        CMD_HOLD     = 4'd15
    } cmd_e;

    localparam int NCMD = 15;

    typedef enum logic [1:0] {
        PWR_RUN  = 2'd0,
        PWR_DOWN = 2'd1,
        PWR_SELF = 2'd2,
        PWR_SUSP = 2'd3
    } pwr_e;

    typedef struct packed {
        logic [2:0] cl;
        logic       ilv;
        logic [2:0] bl;
    } mode_t;

    localparam logic [2:0] BL_FULL = 3'd7;

    function automatic logic [3:0] bl_beats(input logic [2:0] code);
        case (code)
            3'd1:    return 4'd2;
            3'd2:    return 4'd4;
            3'd3:    return 4'd8;
            default: return 4'd1;
        endcase
    endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       cke,
    input  logic       cke_q,
    input  pwr_e       pwr,
    input  logic [1:0] open,
    input  logic       busy,
    input  logic       bank,
    output cmd_e       kind,
    output logic       illegal
);
    logic [2:0] pins;
    logic       pins_quiet;
    logic       any_open;

    assign pins       = {ras_n, cas_n, we_n};
    assign pins_quiet = cs_n || (pins == 3'b111);
    assign any_open   = |open;

    always_comb begin
        kind    = CMD_HOLD;
        illegal = 1'b0;
        unique case (pwr)
            PWR_RUN: begin
                if (cke_q && cke) begin
                    if (cs_n) begin
                        kind = CMD_DESEL;
                    end else begin
                        case (pins)
                            3'b011: begin kind = CMD_ACT;   illegal = open[bank];  end
                            3'b010: begin kind = CMD_PRE;                          end
                            3'b101: begin kind = CMD_READ;  illegal = !open[bank]; end
                            3'b100: begin kind = CMD_WRITE; illegal = !open[bank]; end
                            3'b000: begin kind = CMD_MRS;   illegal = any_open;    end
                            3'b110: begin kind = CMD_BST;   illegal = !any_open;   end
                            3'b001: begin kind = CMD_AREF;  illegal = any_open;    end
                            default: kind = CMD_NOP;
                        endcase
                    end
                end else if (cke_q) begin
                    if (!cs_n && pins == 3'b001 && !any_open) begin
                        kind = CMD_SREF_IN;
                    end else begin
                        kind    = busy ? CMD_SUSP_IN : CMD_PD_IN;
                        illegal = !cs_n && (pins == 3'b001);
                    end
                end
            end
            PWR_SUSP: begin
                if (cke) kind = CMD_SUSP_OUT;
            end
            PWR_DOWN: begin
                if (cke) begin
                    if (pins_quiet) kind = CMD_PD_OUT;
                    else            illegal = 1'b1;
                end
            end
            PWR_SELF: begin
                if (cke) begin
                    if (pins_quiet) kind = CMD_SREF_OUT;
                    else            illegal = 1'b1;
                end
            end
            default: kind = CMD_HOLD;
        endcase
    end
endmodule

// File: rtl/sdcmd_power.sv
module sdcmd_power
    import sdcmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  cmd_e kind,
    output pwr_e pwr,
    output logic cke_q
);
    pwr_e pwr_nx;

    always_comb begin
        pwr_nx = pwr;
        case (kind)
            CMD_SUSP_IN:  pwr_nx = PWR_SUSP;
            CMD_PD_IN:    pwr_nx = PWR_DOWN;
            CMD_SREF_IN:  pwr_nx = PWR_SELF;
            CMD_SUSP_OUT,
            CMD_PD_OUT,
            CMD_SREF_OUT: pwr_nx = PWR_RUN;
            default:      pwr_nx = pwr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr   <= PWR_RUN;
            cke_q <= 1'b1;
        end else begin
            pwr   <= pwr_nx;
            cke_q <= cke;
        end
    end

    // R10: a low clock enable holds power-down
    p_down_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (pwr == PWR_DOWN && !cke) |=> (pwr == PWR_DOWN));

    // R11: a high clock enable always releases clock suspend
    p_susp_release_r11: assert property (@(posedge clk) disable iff (rst)
        (pwr == PWR_SUSP && cke) |=> (pwr == PWR_RUN));
endmodule

// File: rtl/sdcmd_banks.sv
module sdcmd_banks
    import sdcmd_pkg::*;
#(
    parameter int MAX_BEATS = 8,
    localparam int CNT_W    = $clog2(MAX_BEATS + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  cmd_e       kind,
    input  logic       illegal,
    input  logic       bank,
    input  logic       a10,
    input  logic       tick,
    input  logic [2:0] bl_code,
    output logic [1:0] open,
    output logic       busy
);
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             full, full_nx;
    logic             ap, ap_nx;
    logic             apb, apb_nx;
    logic [1:0]       open_nx;

    assign busy = (cnt != '0) || full;

    always_comb begin
        open_nx = open;
        cnt_nx  = cnt;
        full_nx = full;
        ap_nx   = ap;
        apb_nx  = apb;
        if (tick && cnt != '0) begin
            cnt_nx = cnt - 1'b1;
            if (cnt == CNT_W'(1) && ap) begin
                open_nx[apb] = 1'b0;
                ap_nx        = 1'b0;
            end
        end
        if (!illegal) begin
            case (kind)
                CMD_ACT: open_nx[bank] = 1'b1;
                CMD_PRE: begin
                    if (a10) open_nx = '0;
                    else     open_nx[bank] = 1'b0;
                    if (busy && (a10 || bank == apb)) begin
                        cnt_nx  = '0;
                        full_nx = 1'b0;
                        ap_nx   = 1'b0;
                    end
                end
                CMD_READ, CMD_WRITE: begin
                    apb_nx = bank;
                    ap_nx  = a10;
                    if (bl_code == BL_FULL) begin
                        full_nx = 1'b1;
                        cnt_nx  = '0;
                    end else begin
                        full_nx = 1'b0;
                        cnt_nx  = CNT_W'(bl_beats(bl_code));
                    end
                end
                CMD_BST: begin
                    if (busy && ap) open_nx[apb] = 1'b0;
                    cnt_nx  = '0;
                    full_nx = 1'b0;
                    ap_nx   = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open <= '0;
            cnt  <= '0;
            full <= 1'b0;
            ap   <= 1'b0;
            apb  <= 1'b0;
        end else begin
            open <= open_nx;
            cnt  <= cnt_nx;
            full <= full_nx;
            ap   <= ap_nx;
            apb  <= apb_nx;
        end
    end

    // R5: a legal open-row leaves its bank open
    p_act_opens_r5: assert property (@(posedge clk) disable iff (rst)
        (kind == CMD_ACT && !illegal) |=> open[$past(bank)]);

    // R6: an illegal command outside a burst keeps every bank flag
    p_illegal_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (illegal && !busy) |=> $stable(open));

    // R10: no burst progress outside running cycles
    p_frozen_count_r10: assert property (@(posedge clk) disable iff (rst)
        (!tick) |=> ($stable(cnt) && $stable(full)));

    // R8: a full-page burst persists until something ends it
    p_full_persists_r8: assert property (@(posedge clk) disable iff (rst)
        (full && !(kind inside {CMD_BST, CMD_PRE, CMD_READ, CMD_WRITE})) |=> full);
endmodule

// File: rtl/sdcmd_tracker.sv
module sdcmd_tracker
    import sdcmd_pkg::*;
#(
    parameter int          ROW_W     = 11,
    parameter int          COL_W     = 8,
    parameter int          MAX_BEATS = 8,
    parameter logic [6:0]  MODE_RST  = 7'h20,
    localparam int         ADDR_W    = ROW_W + 1,
    localparam int         AP_BIT    = ROW_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [NCMD-1:0]   cmd_stb,
    output logic              cmd_illegal,
    output logic              cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_autopre,
    output logic              cmd_pre_all,
    output logic [1:0]        bank_open,
    output logic [1:0]        pwr_state,
    output logic              burst_busy,
    output logic [2:0]        mode_bl,
    output logic              mode_ilv,
    output logic [2:0]        mode_cl
);
    cmd_e  kind;
    pwr_e  pwr;
    logic  cke_q;
    logic  tick;
    mode_t mode;

    assign cmd_bank = addr[ROW_W];
    assign cmd_row  = addr[ROW_W-1:0];
    assign cmd_col  = addr[COL_W-1:0];
    assign tick     = (pwr == PWR_RUN) && cke && cke_q;

    sdcmd_decode u_decode (
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .cke     (cke),
        .cke_q   (cke_q),
        .pwr     (pwr),
        .open    (bank_open),
        .busy    (burst_busy),
        .bank    (cmd_bank),
        .kind    (kind),
        .illegal (cmd_illegal)
    );

    sdcmd_power u_power (
        .clk   (clk),
        .rst   (rst),
        .cke   (cke),
        .kind  (kind),
        .pwr   (pwr),
        .cke_q (cke_q)
    );

    sdcmd_banks #(.MAX_BEATS(MAX_BEATS)) u_banks (
        .clk     (clk),
        .rst     (rst),
        .kind    (kind),
        .illegal (cmd_illegal),
        .bank    (cmd_bank),
        .a10     (addr[AP_BIT]),
        .tick    (tick),
        .bl_code (mode.bl),
        .open    (bank_open),
        .busy    (burst_busy)
    );

    for (genvar i = 0; i < NCMD; i++) begin : g_stb
        assign cmd_stb[i] = (kind == cmd_e'(i));
    end

    assign cmd_autopre = addr[AP_BIT] && (cmd_stb[CMD_READ] || cmd_stb[CMD_WRITE]);
    assign cmd_pre_all = addr[AP_BIT] && cmd_stb[CMD_PRE];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= mode_t'(MODE_RST);
        end else if (kind == CMD_MRS && !cmd_illegal) begin
            mode <= mode_t'(addr[6:0]);
        end
    end

    assign pwr_state = pwr;
    assign mode_bl   = mode.bl;
    assign mode_ilv  = mode.ilv;
    assign mode_cl   = mode.cl;

    // R2: never more than one command strobe
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_stb));

    // R1: deselect in a running cycle is quiet
    p_desel_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (cs_n && tick) |-> (cmd_stb[CMD_DESEL] && !cmd_illegal));

    // R7: an accepted mode set only with both banks closed
    p_mode_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb[CMD_MRS] && !cmd_illegal) |-> (bank_open == 2'b00));

    // R11: exit from power-down only with quiet pins
    p_pd_exit_r11: assert property (@(posedge clk) disable iff (rst)
        (pwr == PWR_DOWN && cke && !cs_n && {ras_n, cas_n, we_n} != 3'b111)
        |=> (pwr == PWR_DOWN));
endmodule

// File: tb/sdcmd_tracker_bench.sv
module sdcmd_tracker_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst, cke, cs_n, ras_n, cas_n, we_n;
    logic [11:0] addr;
    logic [14:0] cmd_stb;
    logic        cmd_illegal, cmd_bank, cmd_autopre, cmd_pre_all, burst_busy, mode_ilv;
    logic [10:0] cmd_row;
    logic [7:0]  cmd_col;
    logic [1:0]  bank_open, pwr_state;
    logic [2:0]  mode_bl, mode_cl;

    sdcmd_tracker u_sdcmd_tracker (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .addr(addr), .cmd_stb(cmd_stb), .cmd_illegal(cmd_illegal),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .cmd_autopre(cmd_autopre), .cmd_pre_all(cmd_pre_all), .bank_open(bank_open),
        .pwr_state(pwr_state), .burst_busy(burst_busy), .mode_bl(mode_bl),
        .mode_ilv(mode_ilv), .mode_cl(mode_cl)
    );

    localparam logic [2:0] P_ACT = 3'b011, P_PRE = 3'b010, P_RD = 3'b101, P_WR = 3'b100,
                           P_MRS = 3'b000, P_NOP = 3'b111, P_BST = 3'b110, P_REF = 3'b001;
    localparam int K_NOP = 0, K_DESEL = 1, K_ACT = 2, K_PRE = 3, K_RD = 4, K_WR = 5,
                   K_MRS = 6, K_BST = 7, K_AREF = 8, K_SIN = 9, K_SOUT = 10, K_PIN = 11,
                   K_POUT = 12, K_UIN = 13, K_UOUT = 14, K_HOLD = 15;

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // bench model of the requirements
    logic [1:0] m_open;
    int         m_pwr, m_cnt;
    logic       m_ckeq, m_full, m_ap, m_apb;
    logic [6:0] m_mode;

    function automatic int beats(input logic [2:0] c);
        if (c == 3'd1) return 2;
        if (c == 3'd2) return 4;
        if (c == 3'd3) return 8;
        return 1;
    endfunction

    int   e_kind;
    logic e_ill;

    task automatic model_eval(input logic c_cs, input logic [2:0] p, input logic c_cke,
                              input logic [11:0] a);
        logic bk, anyo, bsy, quiet;
        bk = a[11]; anyo = (m_open != 0); bsy = (m_cnt != 0) || m_full;
        quiet = c_cs || (p == P_NOP);
        e_kind = K_HOLD; e_ill = 1'b0;
        if (m_pwr == 0) begin
            if (m_ckeq && c_cke) begin
                if (c_cs) e_kind = K_DESEL;
                else if (p == P_ACT) begin e_kind = K_ACT; e_ill = m_open[bk]; end
                else if (p == P_PRE) e_kind = K_PRE;
                else if (p == P_RD)  begin e_kind = K_RD; e_ill = !m_open[bk]; end
                else if (p == P_WR)  begin e_kind = K_WR; e_ill = !m_open[bk]; end
                else if (p == P_MRS) begin e_kind = K_MRS; e_ill = anyo; end
                else if (p == P_BST) begin e_kind = K_BST; e_ill = !anyo; end
                else if (p == P_REF) begin e_kind = K_AREF; e_ill = anyo; end
                else e_kind = K_NOP;
            end else if (m_ckeq) begin
                if (!c_cs && p == P_REF && !anyo) e_kind = K_SIN;
                else begin
                    e_kind = bsy ? K_UIN : K_PIN;
                    e_ill  = !c_cs && p == P_REF;
                end
            end
        end else if (m_pwr == 3) begin
            if (c_cke) e_kind = K_UOUT;
        end else if (c_cke) begin
            if (quiet) e_kind = (m_pwr == 1) ? K_POUT : K_SOUT;
            else e_ill = 1'b1;
        end
    endtask

    task automatic model_commit(input logic c_cke, input logic [11:0] a);
        logic bk, a10, bsy, tick;
        bk = a[11]; a10 = a[10]; bsy = (m_cnt != 0) || m_full;
        tick = (m_pwr == 0) && c_cke && m_ckeq;
        if (tick && m_cnt != 0) begin
            if (m_cnt == 1 && m_ap) begin m_open[m_apb] = 1'b0; m_ap = 1'b0; end
            m_cnt--;
        end
        if (!e_ill) begin
            case (e_kind)
                K_ACT: m_open[bk] = 1'b1;
                K_PRE: begin
                    if (a10) m_open = 2'b00; else m_open[bk] = 1'b0;
                    if (bsy && (a10 || bk == m_apb)) begin m_cnt = 0; m_full = 0; m_ap = 0; end
                end
                K_RD, K_WR: begin
                    m_apb = bk; m_ap = a10;
                    if (m_mode[2:0] == 3'd7) begin m_full = 1; m_cnt = 0; end
                    else begin m_full = 0; m_cnt = beats(m_mode[2:0]); end
                end
                K_BST: begin
                    if (bsy && m_ap) m_open[m_apb] = 1'b0;
                    m_cnt = 0; m_full = 0; m_ap = 0;
                end
                K_MRS: m_mode = a[6:0];
                default: ;
            endcase
        end
        case (e_kind)
            K_UIN: m_pwr = 3;
            K_PIN: m_pwr = 1;
            K_SIN: m_pwr = 2;
            K_UOUT, K_POUT, K_SOUT: m_pwr = 0;
            default: ;
        endcase
        m_ckeq = c_cke;
    endtask

    task automatic step(input logic c_cs, input logic [2:0] p, input logic c_cke,
                        input logic [11:0] a);
        logic [14:0] e_stb;
        @(negedge clk);
        cs_n = c_cs; {ras_n, cas_n, we_n} = p; cke = c_cke; addr = a;
        #2;
        model_eval(c_cs, p, c_cke, a);
        e_stb = (e_kind == K_HOLD) ? 15'd0 : 15'(1 << e_kind);
        chk("R2 strobe", 32'(cmd_stb), 32'(e_stb));
        chk("R6 illegal", 32'(cmd_illegal), 32'(e_ill));
        chk("R5 bank_open", 32'(bank_open), 32'(m_open));
        chk("R10 pwr_state", 32'(pwr_state), 32'(m_pwr));
        chk("R8 burst_busy", 32'(burst_busy), 32'((m_cnt != 0) || m_full));
        chk("R7 mode", 32'({mode_cl, mode_ilv, mode_bl}), 32'(m_mode));
        chk("R4 fields", 32'({cmd_bank, cmd_row, cmd_col}), 32'({a[11], a[10:0], a[7:0]}));
        chk("R4 qualifiers", 32'({cmd_autopre, cmd_pre_all}),
            32'({a[10] && (e_kind == K_RD || e_kind == K_WR), a[10] && e_kind == K_PRE}));
        @(posedge clk);
        model_commit(c_cke, a);
        #1;
    endtask

    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h0005EED1));
        rst = 1'b1; cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        addr = '0;
        m_open = 0; m_pwr = 0; m_cnt = 0; m_ckeq = 1; m_full = 0; m_ap = 0; m_apb = 0;
        m_mode = 7'h20;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #2;
        chk("R12 reset banks", 32'(bank_open), 0);
        chk("R12 reset power", 32'(pwr_state), 0);
        chk("R12 reset busy", 32'(burst_busy), 0);
        chk("R7 reset latency", 32'(mode_cl), 2);

        step(0, P_MRS, 1, 12'h032);               // bl code 2 -> 4 beats, latency 3
        chk("R7 burst code", 32'(mode_bl), 2);
        step(0, P_ACT, 1, 12'h155);
        chk("R5 open bank0", 32'(bank_open), 32'b01);
        step(1, P_ACT, 1, 12'h955);               // deselect masks an open-row
        chk("R1 deselect keeps banks", 32'(bank_open), 32'b01);
        step(0, P_ACT, 1, 12'h155);               // open-row to open bank
        chk("R6 banks after illegal", 32'(bank_open), 32'b01);
        step(0, P_RD, 1, 12'h43A);                // read, auto-precharge
        chk("R8 busy after read", 32'(burst_busy), 1);
        for (int i = 0; i < 3; i++) step(0, P_NOP, 1, 12'h000);
        chk("R9 still open before last beat", 32'(bank_open), 32'b01);
        step(0, P_NOP, 1, 12'h000);
        chk("R9 closed after last beat", 32'(bank_open), 32'b00);
        chk("R8 burst over", 32'(burst_busy), 0);

        step(0, P_ACT, 1, 12'h812);
        step(0, P_WR, 1, 12'h805);
        step(0, P_NOP, 0, 12'h000);               // fall while bursting
        chk("R10 suspend", 32'(pwr_state), 3);
        step(0, P_NOP, 0, 12'h000);
        step(0, P_NOP, 0, 12'h000);
        chk("R10 frozen burst", 32'(burst_busy), 1);
        step(0, P_RD, 1, 12'h805);                // read pins ignored on exit
        chk("R11 suspend left", 32'(pwr_state), 0);
        step(0, P_PRE, 1, 12'h400);
        chk("R5 precharge both", 32'(bank_open), 32'b00);
        chk("R8 precharge ends burst", 32'(burst_busy), 0);
        step(0, P_REF, 1, 12'h000);
        step(0, P_REF, 0, 12'h000);
        chk("R3 self-refresh", 32'(pwr_state), 2);
        step(0, P_RD, 1, 12'h000);
        chk("R11 bad exit kept", 32'(pwr_state), 2);
        step(1, P_RD, 1, 12'h000);
        chk("R11 self-refresh left", 32'(pwr_state), 0);
        step(0, P_NOP, 1, 12'h000);
        step(0, P_NOP, 0, 12'h000);
        chk("R10 power-down", 32'(pwr_state), 1);
        step(0, P_NOP, 1, 12'h000);
        chk("R11 power-down left", 32'(pwr_state), 0);
        step(0, P_MRS, 1, 12'h007);               // full page
        step(0, P_ACT, 1, 12'h000);
        step(0, P_RD, 1, 12'h400);
        for (int i = 0; i < 12; i++) step(0, P_NOP, 1, 12'h000);
        chk("R8 full page busy", 32'(burst_busy), 1);
        step(0, P_BST, 1, 12'h000);
        chk("R9 stop closes bank", 32'(bank_open), 32'b00);

        for (int n = 0; n < 6000; n++) begin
            logic r_cs, r_cke;
            r_cs  = ($urandom % 8) == 0;
            r_cke = ($urandom % 12) != 0;
            step(r_cs, 3'($urandom), r_cke, 12'($urandom));
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule